// File: doc/BRIEF.md
# Conditional skip decision logic

This block decides whether a skip-class instruction of a 36-bit word machine skips the next instruction. On an execute strobe it looks at the 12-bit address field of the instruction and evaluates the tests that the field enables. The tests read the accumulator, the in-out register, the overflow flip-flop, six sense switches and six program flags. One clock later it raises a one-cycle skip request, which the sequencer uses to advance the program counter by one extra position. In the same cycle it can raise a strobe that clears the overflow flip-flop.

Single address bits each turn on one register test. Two 3-bit subfields each pick one switch or one flag, or the whole group. The skip is the inclusive OR of every enabled test, so one instruction can combine several conditions and still completes in one step. Program counter arithmetic, instruction fetch and the logic that sets the flags live elsewhere.

Top module: `skip_eval`

## Requirements
- R1: With address bit 6 (octal 0100) set, the skip is taken when every accumulator bit is zero.
- R2: With address bit 7 (octal 0200) set, the skip is taken when the accumulator sign bit (its most significant bit) is 0.
- R3: With address bit 8 (octal 0400) set, the skip is taken when the accumulator sign bit is 1.
- R4: With address bit 9 (octal 1000) set, the skip is taken when the overflow input is 0.
- R5: The overflow clear strobe is raised whenever address bit 9 is set, whether or not the skip is taken, and at no other time.
- R6: With address bit 10 (octal 2000) set, the skip is taken when the in-out register sign bit (its most significant bit) is 0.
- R7: The switch field, address bits 5:3, with a value n from 1 to 6 skips when sense switch n (input bit n-1) is 0.
- R8: A switch field value of 7 skips only when all six switches are 0. A value of 0 selects no switch.
- R9: The flag field, address bits 2:0, with a value n from 1 to 6 skips when program flag n (input bit n-1) is 0. A value of 7 needs all six flags to be 0, and a value of 0 selects no flag.
- R10: When several tests are enabled, the skip is taken if any one of them holds. With no test enabled, no skip is taken.
- R11: Address bit 11 (octal 4000) has no effect on either output.
- R12: Both outputs are registered. Each is valid for exactly one cycle, in the cycle after the clock edge that samples the execute strobe high. Both are 0 after reset and after any edge that samples the strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Single-cycle strobe: evaluate the instruction |
| addr_i | input | 12 | Address field of the skip instruction |
| acc_i | input | 36 | Accumulator, sign in the most significant bit |
| io_i | input | 36 | In-out register, sign in the most significant bit |
| ovf_i | input | 1 | Overflow flip-flop state |
| sense_i | input | 6 | Sense switches; bit n-1 is switch n |
| flag_i | input | 6 | Program flags; bit n-1 is flag n |
| skip_o | output | 1 | One-cycle request to skip the next instruction |
| ovf_clr_o | output | 1 | One-cycle strobe that clears the overflow flip-flop |

## Verification
A fault in the decode shows up as a wrong skip_o in the cycle right after the strobe. There is no other state to hide it, so every fault becomes visible one clock after the instruction that exposes it. The bench drives all 4096 address encodings against two contrasting operand sets, which covers every single test and every combination. A stuck output register shows up either as a pulse that lasts beyond one cycle or as a pulse that never arrives. The bench therefore also samples the outputs in the cycle after each pulse and while the strobe is low.

// File: rtl/skip_pkg.sv
package skip_pkg;
  // Address bit positions of the single-bit register tests
  localparam int unsigned BIT_ACC_ZERO  = 6;
  localparam int unsigned BIT_ACC_PLUS  = 7;
  localparam int unsigned BIT_ACC_MINUS = 8;
  localparam int unsigned BIT_OVF_ZERO  = 9;
  localparam int unsigned BIT_IO_PLUS   = 10;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned SW_LSB        = 3;
  localparam int unsigned FLAG_LSB      = 0;

  typedef struct packed {
    logic acc_zero;
    logic acc_plus;
    logic acc_minus;
    logic ovf_zero;
    logic io_plus;
    logic sw_hit;
    logic flag_hit;
  } skip_hits_t;
endpackage

// File: rtl/skip_sel_zero.sv
// Picks one of N inputs (code 1..N) or all of them (code all-ones) and
// reports whether the selection reads zero. Code 0 selects nothing.
module skip_sel_zero #(
  parameter int unsigned N     = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N-1:0]     bits_i,
  output logic             hit_o
);
  localparam logic [SEL_W-1:0] ALL_CODE = '1;

  logic [N-1:0] one_hit;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_pick
      assign one_hit[gi] = (sel_i == SEL_W'(gi + 1)) && !bits_i[gi];
    end
  endgenerate

  assign hit_o = (|one_hit) || ((sel_i == ALL_CODE) && (bits_i == '0));
endmodule

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
  import skip_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned N_SW   = 6,
  parameter int unsigned N_FLAG = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              io_sign_i,
  input  logic              ovf_i,
  input  logic [N_SW-1:0]   sense_i,
  input  logic [N_FLAG-1:0] flag_i,
  output skip_hits_t        hits_o
);
  logic sw_hit;
  logic flag_hit;

  skip_sel_zero #(.N(N_SW), .SEL_W(SEL_W)) u_sw (
    .sel_i  (addr_i[SW_LSB +: SEL_W]),
    .bits_i (sense_i),
    .hit_o  (sw_hit)
  );

  skip_sel_zero #(.N(N_FLAG), .SEL_W(SEL_W)) u_flag (
    .sel_i  (addr_i[FLAG_LSB +: SEL_W]),
    .bits_i (flag_i),
    .hit_o  (flag_hit)
  );

  always_comb begin
    hits_o.acc_zero  = addr_i[BIT_ACC_ZERO]  && (acc_i == '0);
    hits_o.acc_plus  = addr_i[BIT_ACC_PLUS]  && !acc_i[WORD_W-1];
    hits_o.acc_minus = addr_i[BIT_ACC_MINUS] &&  acc_i[WORD_W-1];
    hits_o.ovf_zero  = addr_i[BIT_OVF_ZERO]  && !ovf_i;
    hits_o.io_plus   = addr_i[BIT_IO_PLUS]   && !io_sign_i;
    hits_o.sw_hit    = sw_hit;
    hits_o.flag_hit  = flag_hit;
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned N_SW   = 6,
  parameter int unsigned N_FLAG = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] io_i,
  input  logic              ovf_i,
  input  logic [N_SW-1:0]   sense_i,
  input  logic [N_FLAG-1:0] flag_i,
  output logic              skip_o,
  output logic              ovf_clr_o
);
  localparam int unsigned TOP_BIT = BIT_IO_PLUS + 1;

  skip_hits_t hits;
  logic       any_hit;
  logic       unused_bits;

  // Address bits above the io test and the io magnitude play no part
  assign unused_bits = ^{addr_i[ADDR_W-1:TOP_BIT], io_i[WORD_W-2:0]};

  skip_cond_eval #(
    .ADDR_W (ADDR_W), .WORD_W (WORD_W), .N_SW (N_SW), .N_FLAG (N_FLAG)
  ) u_eval (
    .addr_i    (addr_i),
    .acc_i     (acc_i),
    .io_sign_i (io_i[WORD_W-1]),
    .ovf_i     (ovf_i),
    .sense_i   (sense_i),
    .flag_i    (flag_i),
    .hits_o    (hits)
  );

  assign any_hit = |hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_o    <= 1'b0;
      ovf_clr_o <= 1'b0;
    end else begin
      skip_o    <= exec_i && any_hit;
      ovf_clr_o <= exec_i && addr_i[BIT_OVF_ZERO];
    end
  end
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WORD_W = 36,
  parameter int unsigned N_SW   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] acc_i,
  input logic              ovf_i,
  input logic [N_SW-1:0]   sense_i,
  input logic              skip_o,
  input logic              ovf_clr_o
);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> (!skip_o && !ovf_clr_o));

  assert_acc_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (exec_i && addr_i[6] && (acc_i == '0)) |=> skip_o);

  assert_acc_minus_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_i && addr_i[8] && acc_i[WORD_W-1]) |=> skip_o);

  assert_ovf_skip_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_i && addr_i[9] && !ovf_i) |=> skip_o);

  assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> (ovf_clr_o == $past(addr_i[9])));

  assert_all_switches_R8: assert property (@(posedge clk) disable iff (rst)
    (exec_i && (addr_i[5:3] == 3'd7) && (sense_i == '0)) |=> skip_o);

  assert_nothing_selected_R10: assert property (@(posedge clk) disable iff (rst)
    (exec_i && (addr_i[10:0] == '0)) |=> !skip_o);
endmodule

bind skip_eval skip_eval_chk #(
  .ADDR_W (ADDR_W), .WORD_W (WORD_W), .N_SW (N_SW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .exec_i    (exec_i),
  .addr_i    (addr_i),
  .acc_i     (acc_i),
  .ovf_i     (ovf_i),
  .sense_i   (sense_i),
  .skip_o    (skip_o),
  .ovf_clr_o (ovf_clr_o)
);

// File: tb/tb_skip_eval.sv
`timescale 1ns/1ps
module tb_skip_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [35:0] acc_i = '0;
  logic [35:0] io_i = '0;
  logic        ovf_i = 1'b0;
  logic [5:0]  sense_i = '0;
  logic [5:0]  flag_i = '0;
  logic        skip_o;
  logic        ovf_clr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  skip_eval dut (
    .clk (clk), .rst (rst), .exec_i (exec_i), .addr_i (addr_i),
    .acc_i (acc_i), .io_i (io_i), .ovf_i (ovf_i), .sense_i (sense_i),
    .flag_i (flag_i), .skip_o (skip_o), .ovf_clr_o (ovf_clr_o)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [35:0] acc;
    logic [35:0] io;
    logic        ovf;
    logic [5:0]  sense;
    logic [5:0]  flag;
    logic        skip;
    logic        clr;
  } vec_t;

  localparam logic [35:0] NEG = 36'o400000000000;
  localparam logic [35:0] POS = 36'o377777777777;
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{12'o0100, 36'o0,  NEG, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0}, // R1 zero acc
    '{12'o0100, 36'o1,  NEG, 1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R1 nonzero
    '{12'o0200, POS,    NEG, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0}, // R2 plus
    '{12'o0200, NEG,    NEG, 1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R2 minus
    '{12'o0400, NEG,    NEG, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0}, // R3 minus
    '{12'o0400, 36'o0,  NEG, 1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R3 zero
    '{12'o1000, 36'o1,  NEG, 1'b0, 6'o77, 6'o77, 1'b1, 1'b1}, // R4 R5
    '{12'o1000, 36'o1,  NEG, 1'b1, 6'o77, 6'o77, 1'b0, 1'b1}, // R4 R5 no skip
    '{12'o2000, 36'o1,  36'o0, 1'b1, 6'o77, 6'o77, 1'b1, 1'b0}, // R6
    '{12'o2000, 36'o1,  NEG, 1'b1, 6'o77, 6'o77, 1'b0, 1'b0}, // R6 negative
    '{12'o0030, 36'o1,  NEG, 1'b1, 6'b111011, 6'o77, 1'b1, 1'b0}, // R7 sw3 off
    '{12'o0030, 36'o1,  NEG, 1'b1, 6'b000100, 6'o00, 1'b0, 1'b0}, // R7 sw3 on
    '{12'o0070, 36'o1,  NEG, 1'b1, 6'o00, 6'o77, 1'b1, 1'b0}, // R8 all off
    '{12'o0070, 36'o1,  NEG, 1'b1, 6'b100000, 6'o77, 1'b0, 1'b0}, // R8 one on
    '{12'o0005, 36'o1,  NEG, 1'b1, 6'o77, 6'b101111, 1'b1, 1'b0}, // R9 flag5
    '{12'o0007, 36'o1,  NEG, 1'b1, 6'o77, 6'b000001, 1'b0, 1'b0}, // R9 all
    '{12'o0000, 36'o0,  36'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0}, // R10 none
    '{12'o3000, 36'o1,  36'o0, 1'b1, 6'o77, 6'o77, 1'b1, 1'b1}, // R10 OR
    '{12'o3000, 36'o1,  NEG, 1'b1, 6'o77, 6'o77, 1'b0, 1'b1}, // R10 OR none
    '{12'o4000, 36'o0,  36'o0, 1'b0, 6'o00, 6'o00, 1'b0, 1'b0}  // R11 ignored
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one instruction; sample both outputs in the cycle after the edge
  task automatic issue(input vec_t v);
    @(negedge clk);
    addr_i = v.addr; acc_i = v.acc; io_i = v.io; ovf_i = v.ovf;
    sense_i = v.sense; flag_i = v.flag; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  // Expected skip written from the requirement text
  function automatic logic model(input vec_t v);
    logic r = 1'b0;
    int sw = int'(v.addr[5:3]);
    int fl = int'(v.addr[2:0]);
    if (v.addr[6] && v.acc == 36'o0) r = 1'b1;
    if (v.addr[7] && v.acc < NEG) r = 1'b1;
    if (v.addr[8] && v.acc >= NEG) r = 1'b1;
    if (v.addr[9] && v.ovf == 1'b0) r = 1'b1;
    if (v.addr[10] && v.io < NEG) r = 1'b1;
    if (sw == 7 && v.sense == 6'o00) r = 1'b1;
    if (sw >= 1 && sw <= 6 && ((v.sense >> (sw - 1)) & 6'd1) == 6'd0) r = 1'b1;
    if (fl == 7 && v.flag == 6'o00) r = 1'b1;
    if (fl >= 1 && fl <= 6 && ((v.flag >> (fl - 1)) & 6'd1) == 6'd0) r = 1'b1;
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    // Reset state, R12
    @(negedge clk); @(negedge clk);
    check("R12 reset skip", skip_o, 1'b0);
    check("R12 reset clr", ovf_clr_o, 1'b0);
    rst = 1'b0;

    // Table, R1..R11
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i]);
      check($sformatf("table row %0d skip", i), skip_o, VEC[i].skip);
      check($sformatf("table row %0d clr", i), ovf_clr_o, VEC[i].clr);
    end

    // R12: pulse lasts one cycle only
    issue('{12'o1100, 36'o0, 36'o0, 1'b0, 6'o0, 6'o0, 1'b1, 1'b1});
    check("R12 pulse skip", skip_o, 1'b1);
    @(negedge clk);
    check("R12 pulse ends skip", skip_o, 1'b0);
    check("R12 pulse ends clr", ovf_clr_o, 1'b0);

    // R12: strobe low, every test true -> nothing
    addr_i = 12'o3777; acc_i = '0; io_i = '0; ovf_i = 1'b0;
    sense_i = '0; flag_i = '0;
    @(negedge clk);
    check("R12 idle skip", skip_o, 1'b0);
    check("R12 idle clr", ovf_clr_o, 1'b0);

    // R10 R5 R11: full sweep of address encodings, two operand sets
    for (int a = 0; a < 4096; a++) begin
      v = '{12'(a), NEG, 36'o0, 1'b1, 6'b101010, 6'b010101, 1'b0, 1'b0};
      issue(v);
      check($sformatf("R10 sweep A addr %o skip", a), skip_o, model(v));
      check($sformatf("R5 sweep A addr %o clr", a), ovf_clr_o, v.addr[9]);
      v = '{12'(a), 36'o0, NEG, 1'b0, 6'o00, 6'o77, 1'b0, 1'b0};
      issue(v);
      check($sformatf("R10 sweep B addr %o skip", a), skip_o, model(v));
      check($sformatf("R5 sweep B addr %o clr", a), ovf_clr_o, v.addr[9]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule